// File: doc/BRIEF.md
# Winner-Take-All Refractory Arbiter

This block arbitrates the firing of a bank of output spiking neurons. Threshold comparators outside the block raise one fire request per neuron. The block accepts at most one firing per clock cycle. It reports the winner's index with a one-cycle valid strobe. It also pulses a reset line to every other neuron, so that their membranes restart integration.

The block has a training mode. In training, the neuron that won is then held: its inhibit and reset lines stay high until a set number of accepted firings from other neurons have occurred. This spreads learning across the bank and stops one neuron from taking all the activity. Release is counted in firings, not in clock cycles. In inference, there is no holding and only the winner-take-all reset is applied.

Top module: `wta_refrac_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears all inhibits and refractory counters. On the cycle after a reset edge, `win_valid`, `win_idx`, `nrn_reset` and `nrn_inhibit` are all zero.
- R2: An accepted firing sampled at a clock edge gives `win_valid` high for exactly that following cycle. In that cycle, `win_idx` holds the winner's index (bit position in `fire_req`).
- R3: In the cycle that `win_valid` is high, `nrn_reset` is high for every neuron other than the winner.
- R4: When several eligible requests are sampled at the same edge, the lowest index wins. The other requests are discarded and do not carry over to later cycles.
- R5: In training mode (`train_mode` = 1), the winner's `nrn_inhibit` and `nrn_reset` bits are high from the cycle after its firing until it is released.
- R6: A held neuron is released at the edge that samples the `REFRAC_CNT`-th accepted firing of another neuron after its own firing (default 10). Its inhibit is low from the next cycle. In that same cycle its reset is still pulsed by the winner-take-all reset, and it is low in the cycle after.
- R7: While a neuron's inhibit is high and `train_mode` is 1, its fire request is ignored. It produces no strobe, and it does not advance any other neuron's refractory count.
- R8: When `train_mode` is sampled low, all inhibits and counters clear at that edge. Every request is then eligible, and a winner is never held.
- R9: `win_idx` is zero in every cycle in which `win_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_mode | input | 1 | 1 = training (refractory holding active), 0 = inference |
| fire_req | input | N_NEURONS | Per-neuron fire request, bit i for neuron i |
| nrn_reset | output | N_NEURONS | Per-neuron membrane reset |
| nrn_inhibit | output | N_NEURONS | Per-neuron refractory hold |
| win_idx | output | $clog2(N_NEURONS) | Index of the accepted winner |
| win_valid | output | 1 | One-cycle strobe per accepted firing |

## Verification
The assertions check several properties on every cycle:
- an eligible request always produces a strobe on the next cycle;
- no strobe appears without one;
- at least N−1 reset lines are high with each strobe;
- inhibits are clear after inference cycles and after reset;
- the index is zero when no strobe is present.

Other behaviours depend on exact history, and only the bench's scenarios can show them:
- the lowest-index choice among colliding requests;
- release on exactly the tenth firing from another neuron;
- ignored requests leaving the counts untouched.

The bench covers these through directed sequences and through a cycle-accurate reference model that it compares on every cycle.

// File: rtl/wta_pkg.sv
package wta_pkg;

  // width of an index into n items (at least 1 bit)
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a counter that must reach the value lim
  function automatic int cnt_width(input int lim);
    return $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/wta_prio_enc.sv
module wta_prio_enc #(
  parameter int N     = 100,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);

  // isolate the lowest set bit
  assign onehot = req & (~req + N'(1));
  assign found  = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/wta_refrac_cell.sv
module wta_refrac_cell #(
  parameter int LIMIT = 10,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic train_mode,
  input  logic accept,
  input  logic is_winner,
  output logic inhibit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             inh_q;

  // saturating increment of other-neuron firings
  assign cnt_inc = (cnt_q == CNT_W'(LIMIT)) ? cnt_q : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !train_mode) begin
      cnt_q <= '0;
      inh_q <= 1'b0;
    end else if (accept) begin
      if (is_winner) begin
        cnt_q <= '0;
        inh_q <= 1'b1;
      end else begin
        cnt_q <= cnt_inc;
        inh_q <= inh_q && (cnt_inc < CNT_W'(LIMIT));
      end
    end
  end

  assign inhibit = inh_q;

endmodule

// File: rtl/wta_refrac_arbiter.sv
module wta_refrac_arbiter #(
  parameter int N_NEURONS  = 100,
  parameter int REFRAC_CNT = 10,
  localparam int IDX_W = wta_pkg::idx_width(N_NEURONS),
  localparam int CNT_W = wta_pkg::cnt_width(REFRAC_CNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 train_mode,
  input  logic [N_NEURONS-1:0] fire_req,
  output logic [N_NEURONS-1:0] nrn_reset,
  output logic [N_NEURONS-1:0] nrn_inhibit,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 win_valid
);

  logic [N_NEURONS-1:0] inh_vec;
  logic [N_NEURONS-1:0] eligible;
  logic [N_NEURONS-1:0] win_oh;
  logic [IDX_W-1:0]     enc_idx;
  logic                 accept;

  logic [N_NEURONS-1:0] pulse_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 valid_q;

  assign eligible = fire_req & ~(inh_vec & {N_NEURONS{train_mode}});

  wta_prio_enc #(.N(N_NEURONS), .IDX_W(IDX_W)) i_enc (
    .req    (eligible),
    .found  (accept),
    .idx    (enc_idx),
    .onehot (win_oh)
  );

  for (genvar g = 0; g < N_NEURONS; g++) begin : g_cell
    wta_refrac_cell #(.LIMIT(REFRAC_CNT), .CNT_W(CNT_W)) i_cell (
      .clk        (clk),
      .rst        (rst),
      .train_mode (train_mode),
      .accept     (accept),
      .is_winner  (win_oh[g]),
      .inhibit    (inh_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      pulse_q <= '0;
    end else begin
      valid_q <= accept;
      idx_q   <= accept ? enc_idx : '0;
      pulse_q <= accept ? ~win_oh : '0;
    end
  end

  assign nrn_reset   = pulse_q | inh_vec;
  assign nrn_inhibit = inh_vec;
  assign win_idx     = idx_q;
  assign win_valid   = valid_q;

endmodule

// File: rtl/wta_arbiter_chk.sv
module wta_arbiter_chk #(
  parameter int N_NEURONS = 100,
  parameter int IDX_W     = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 train_mode,
  input logic [N_NEURONS-1:0] fire_req,
  input logic [N_NEURONS-1:0] nrn_reset,
  input logic [N_NEURONS-1:0] nrn_inhibit,
  input logic [IDX_W-1:0]     win_idx,
  input logic                 win_valid
);

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!win_valid && nrn_inhibit == '0 && win_idx == '0));

  // R2
  eligible_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    ((fire_req & ~(nrn_inhibit & {N_NEURONS{train_mode}})) != '0) |=> win_valid);

  // R7
  no_eligible_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((fire_req & ~(nrn_inhibit & {N_NEURONS{train_mode}})) == '0) |=> !win_valid);

  // R3
  others_reset_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ($countones(nrn_reset) >= N_NEURONS - 1));

  // R8
  inference_free_chk: assert property (@(posedge clk) disable iff (rst)
    !train_mode |=> (nrn_inhibit == '0));

  // R9
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (win_idx == '0));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (int'(win_idx) < N_NEURONS));

endmodule

bind wta_refrac_arbiter wta_arbiter_chk #(.N_NEURONS(N_NEURONS), .IDX_W(IDX_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .train_mode  (train_mode),
  .fire_req    (fire_req),
  .nrn_reset   (nrn_reset),
  .nrn_inhibit (nrn_inhibit),
  .win_idx     (win_idx),
  .win_valid   (win_valid)
);

// File: tb/test_wta_refrac_arbiter.sv
module test_wta_refrac_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 100;
  localparam int RC = 10;
  localparam int IW = $clog2(N);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         train_mode = 1'b1;
  logic [N-1:0] fire_req = '0;
  logic [N-1:0] nrn_reset;
  logic [N-1:0] nrn_inhibit;
  logic [IW-1:0] win_idx;
  logic         win_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [N-1:0]  m_inh = '0;
  int            m_cnt [N];
  logic          e_valid = 1'b0;
  logic [IW-1:0] e_idx = '0;
  logic [N-1:0]  e_reset = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wta_refrac_arbiter #(.N_NEURONS(N), .REFRAC_CNT(RC)) i_wta_refrac_arbiter (
    .clk(clk), .rst(rst), .train_mode(train_mode), .fire_req(fire_req),
    .nrn_reset(nrn_reset), .nrn_inhibit(nrn_inhibit),
    .win_idx(win_idx), .win_valid(win_valid)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // advance the model by one edge with the given inputs
  task automatic model_step(input logic [N-1:0] req, input logic tr, input logic r);
    logic [N-1:0] elig;
    int w;
    w = -1;
    if (r || !tr) begin
      for (int j = 0; j < N; j++) m_cnt[j] = 0;
    end
    if (r) begin
      m_inh = '0; e_valid = 0; e_idx = '0; e_reset = '0;
      return;
    end
    elig = req & ~(tr ? m_inh : '0);
    for (int j = N - 1; j >= 0; j--) if (elig[j]) w = j;
    if (!tr) m_inh = '0;
    else if (w >= 0) begin
      for (int j = 0; j < N; j++) begin
        if (j == w) begin m_inh[j] = 1'b1; m_cnt[j] = 0; end
        else begin
          if (m_cnt[j] < RC) m_cnt[j]++;
          if (m_cnt[j] >= RC) m_inh[j] = 1'b0;
        end
      end
    end
    e_valid = (w >= 0);
    e_idx   = (w >= 0) ? IW'(w) : '0;
    e_reset = m_inh;
    if (w >= 0) for (int j = 0; j < N; j++) if (j != w) e_reset[j] = 1'b1;
  endtask

  // drive one cycle, then compare all outputs after the edge
  task automatic cyc(input logic [N-1:0] req, input logic tr, input logic r);
    fire_req = req; train_mode = tr; rst = r;
    model_step(req, tr, r);
    @(negedge clk);
    chk("R2", N'(win_valid), N'(e_valid));
    chk(e_valid ? "R2" : "R9", N'(win_idx), N'(e_idx));
    chk("R3", nrn_reset, e_reset);
    chk("R5", nrn_inhibit, m_inh);
  endtask

  function automatic logic [N-1:0] bit_of(input int i);
    return N'(1) << i;
  endfunction

  initial begin
    for (int j = 0; j < N; j++) m_cnt[j] = 0;
    void'($urandom(32'd5150));
    @(negedge clk);
    cyc('0, 1, 1);
    // R1 reset state
    chk("R1", {win_valid, nrn_inhibit, nrn_reset}, '0);

    // R4 simultaneous requests: lowest index wins
    cyc(bit_of(40) | bit_of(12) | bit_of(77), 1, 0);
    chk("R4", N'(win_idx), N'(12));
    chk("R4", nrn_inhibit, bit_of(12));
    cyc('0, 1, 0);
    chk("R4", N'(win_valid), N'(0));   // losers discarded

    // R6 / R7: release of neuron 12 after exactly RC other firings
    for (int k = 0; k < RC - 1; k++) begin
      cyc(bit_of(20 + k), 1, 0);
      cyc(bit_of(12), 1, 0);           // ignored while held
      chk("R7", N'(win_valid), N'(0));
    end
    chk("R6", N'(nrn_inhibit[12]), N'(1));
    cyc(bit_of(60), 1, 0);
    chk("R6", N'(nrn_inhibit[12]), N'(0));
    chk("R6", N'(nrn_reset[12]), N'(1));
    cyc('0, 1, 0);
    chk("R6", N'(nrn_reset[12]), N'(0));
    cyc(bit_of(12), 1, 0);
    chk("R6", N'(win_valid && win_idx == IW'(12)), N'(1));

    // R8 inference: no holding
    cyc(bit_of(5), 0, 0);
    chk("R8", nrn_inhibit, '0);
    cyc(bit_of(5), 0, 0);
    chk("R8", N'(win_valid && win_idx == IW'(5)), N'(1));
    chk("R8", N'(nrn_reset[5]), N'(0));

    // R1 reset mid-run clears holds
    cyc(bit_of(3), 1, 0);
    cyc('0, 1, 1);
    chk("R1", nrn_inhibit, '0);
    cyc(bit_of(3), 1, 0);
    chk("R1", N'(win_valid), N'(1));

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] rq;
      int nreq;
      rq = '0;
      nreq = $urandom_range(0, 3);
      for (int q = 0; q < nreq; q++) rq[$urandom_range(0, N - 1)] = 1'b1;
      cyc(rq, ($urandom_range(0, 99) < 95), ($urandom_range(0, 499) == 0));
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule